// File: doc/BRIEF.md
# Triple-Copy Voting Word Store

This block is a small word-addressed store that survives transient bit upsets. Every word is held in three independent copies. A write places the same data in all three. A read looks at all three copies at once and returns the bit-by-bit majority, so one disturbed copy never reaches the requester. When the copies do not agree, the read response carries a corrected flag. In the cycle after the read, the voted word is written back to every copy, so the upset is scrubbed away before a second one can add to it.

Requests arrive on a valid/ready channel: operation, address and write data. Responses leave on a valid/ready channel carrying the read data and the corrected flag. A response marks completion, so the requester never needs to know how long an operation takes. The request channel applies back-pressure in two cases: during the write-back cycle, and while a response is waiting. In both cases `req_ready` is low, and a request is accepted only on an edge where `req_valid` and `req_ready` are both high. A response stays valid, with its data and flag unchanged, until the edge where `rsp_ready` is high. A plain fault-injection port XORs a mask into one chosen copy of one word, so that upsets can be caused on demand.

Top module: `tmr_word_store`

## Requirements
- R1: After reset all three copies of every word are zero, `req_ready` is high and `rsp_valid` is low. A read then returns 0 with the corrected flag low.
- R2: An accepted write (`req_write`=1) stores its data into all three copies. `rsp_valid` rises in the cycle after acceptance, with `rsp_rdata` equal to the written word and `rsp_corrected` low.
- R3: An accepted read whose three copies agree is answered in the cycle after acceptance with the stored word and `rsp_corrected` low.
- R4: Read data is the per-bit majority of the three copies. A bit flipped in only one copy, in any copy, does not change the result. The same bit flipped in two copies does change it.
- R5: `rsp_corrected` is high with the read data whenever any copy differs from the voted word.
- R6: On a read with disagreement, the voted word is written to all three copies in the cycle after acceptance, and the response appears one cycle later than for a clean read. A second read of that address is clean.
- R7: `req_ready` is low during the write-back cycle. It is also low in any cycle where `rsp_valid` is high and `rsp_ready` is low.
- R8: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_rdata` and `rsp_corrected` hold their values.
- R9: With `inj_en` high, the word at `inj_addr` in copy `inj_copy` (0, 1 or 2) is XORed with `inj_mask` at the clock edge. The other copies and other addresses are untouched. An `inj_copy` of 3 changes nothing.
- R10: If an injection lands on the same edge as a write or write-back to the same address, the selected copy ends up holding the written word XOR the mask. A read accepted on the same edge as an injection votes on the contents from before the injection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response present (operation done) |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_rdata | output | DATA_W | Voted read data, or the written word for writes |
| rsp_corrected | output | 1 | At least one copy disagreed with the vote |
| inj_en | input | 1 | Apply a fault this edge |
| inj_copy | input | 2 | Copy to disturb (0..2, 3 = none) |
| inj_addr | input | ADDR_W | Word to disturb |
| inj_mask | input | DATA_W | Bits to invert |

## Verification
Two functions can meet on one edge: a fault injection, and a store into the same word. The store can be a user write or the scrub write-back. The bench drives a write and an injection to the same address in the same cycle. A following read must then come back corrected, two cycles after acceptance, with the written value, and a read after that must be clean. The bench also drives a read and an injection together. The read must see the undisturbed word with no correction, and only the next read may report the fault.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NCOPY = 3;
  localparam int SEL_W = 2;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_SCRUB = 1'b1
  } ctrl_state_t;
endpackage

// File: rtl/tmr_copy_bank.sv
module tmr_copy_bank #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              flip_en,
  input  logic [ADDR_W-1:0] flip_addr,
  input  logic [DATA_W-1:0] flip_mask,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  // A fault lands on top of whatever is being stored on the same edge.
  always_ff @(posedge clk) begin
    for (int w = 0; w < DEPTH; w++) begin
      if (!rst_n) begin
        cells[w] <= '0;
      end else begin
        cells[w] <= ((wr_en && wr_addr == ADDR_W'(w)) ? wr_data : cells[w])
                  ^ ((flip_en && flip_addr == ADDR_W'(w)) ? flip_mask : '0);
      end
    end
  end

  assign rd_data = cells[rd_addr];
endmodule

// File: rtl/tmr_vote.sv
module tmr_vote #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] copy_a,
  input  logic [DATA_W-1:0] copy_b,
  input  logic [DATA_W-1:0] copy_c,
  output logic [DATA_W-1:0] voted,
  output logic              mismatch
);
  always_comb begin
    voted    = (copy_a & copy_b) | (copy_a & copy_c) | (copy_b & copy_c);
    mismatch = |((copy_a ^ voted) | (copy_b ^ voted) | (copy_c ^ voted));
  end
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_corrected,
  input  logic [DATA_W-1:0] voted,
  input  logic              mismatch,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  ctrl_state_t       st;
  logic [ADDR_W-1:0] scrub_addr;
  logic [DATA_W-1:0] scrub_data;
  logic              accept;

  assign req_ready = (st == ST_IDLE) && (!rsp_valid || rsp_ready);
  assign accept    = req_valid && req_ready;
  assign rd_addr   = req_addr;

  always_comb begin
    wr_en   = 1'b0;
    wr_addr = req_addr;
    wr_data = req_wdata;
    if (st == ST_SCRUB) begin
      wr_en   = 1'b1;
      wr_addr = scrub_addr;
      wr_data = scrub_data;
    end else if (accept && req_write) begin
      wr_en = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st            <= ST_IDLE;
      scrub_addr    <= '0;
      scrub_data    <= '0;
      rsp_valid     <= 1'b0;
      rsp_rdata     <= '0;
      rsp_corrected <= 1'b0;
    end else begin
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
      if (st == ST_SCRUB) begin
        st            <= ST_IDLE;
        rsp_valid     <= 1'b1;
        rsp_rdata     <= scrub_data;
        rsp_corrected <= 1'b1;
      end else if (accept) begin
        if (req_write) begin
          rsp_valid     <= 1'b1;
          rsp_rdata     <= req_wdata;
          rsp_corrected <= 1'b0;
        end else if (mismatch) begin
          st         <= ST_SCRUB;
          scrub_addr <= req_addr;
          scrub_data <= voted;
        end else begin
          rsp_valid     <= 1'b1;
          rsp_rdata     <= voted;
          rsp_corrected <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/tmr_word_store.sv
module tmr_word_store
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_corrected,
  input  logic              inj_en,
  input  logic [SEL_W-1:0]  inj_copy,
  input  logic [ADDR_W-1:0] inj_addr,
  input  logic [DATA_W-1:0] inj_mask
);
  logic [DATA_W-1:0] copy_q [NCOPY];
  logic [DATA_W-1:0] vote_word;
  logic              vote_miss;
  logic [ADDR_W-1:0] rd_addr;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;

  for (genvar c = 0; c < NCOPY; c++) begin : g_copy
    tmr_copy_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .flip_en  (inj_en && inj_copy == SEL_W'(c)),
      .flip_addr(inj_addr),
      .flip_mask(inj_mask),
      .rd_addr  (rd_addr),
      .rd_data  (copy_q[c])
    );
  end

  tmr_vote #(.DATA_W(DATA_W)) u_vote (
    .copy_a  (copy_q[0]),
    .copy_b  (copy_q[1]),
    .copy_c  (copy_q[2]),
    .voted   (vote_word),
    .mismatch(vote_miss)
  );

  tmr_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_write    (req_write),
    .req_addr     (req_addr),
    .req_wdata    (req_wdata),
    .rsp_valid    (rsp_valid),
    .rsp_ready    (rsp_ready),
    .rsp_rdata    (rsp_rdata),
    .rsp_corrected(rsp_corrected),
    .voted        (vote_word),
    .mismatch     (vote_miss),
    .rd_addr      (rd_addr),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data)
  );
endmodule

// File: rtl/tmr_word_store_chk.sv
module tmr_word_store_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              rsp_corrected,
  input logic [DATA_W-1:0] vote_word,
  input logic              vote_miss
);
  logic take_rd, take_wr;
  assign take_rd = req_valid && req_ready && !req_write;
  assign take_wr = req_valid && req_ready && req_write;

  // R2
  write_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_wr |=> rsp_valid && !rsp_corrected && rsp_rdata == $past(req_wdata));

  // R3
  clean_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_rd && !vote_miss |=> rsp_valid && !rsp_corrected && rsp_rdata == $past(vote_word));

  // R7
  scrub_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_rd && vote_miss |=> !rsp_valid && !req_ready);

  // R6
  scrub_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_rd && vote_miss |=> ##1 (rsp_valid && rsp_corrected));

  // R7
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);

  // R8
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_corrected));
endmodule

bind tmr_word_store tmr_word_store_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_write    (req_write),
  .req_wdata    (req_wdata),
  .rsp_valid    (rsp_valid),
  .rsp_ready    (rsp_ready),
  .rsp_rdata    (rsp_rdata),
  .rsp_corrected(rsp_corrected),
  .vote_word    (vote_word),
  .vote_miss    (vote_miss)
);

// File: tb/tmr_word_store_bench.sv
module tmr_word_store_bench;
  localparam int AW = 4;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, rsp_valid, rsp_corrected;
  logic          rsp_ready = 1'b1;
  logic [DW-1:0] rsp_rdata;
  logic          inj_en = 1'b0;
  logic [1:0]    inj_copy = '0;
  logic [AW-1:0] inj_addr = '0;
  logic [DW-1:0] inj_mask = '0;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [DW-1:0] got_data;
  logic          got_corr;
  int            got_lat;

  always #5 clk = ~clk;

  tmr_word_store #(.ADDR_W(AW), .DATA_W(DW)) u_tmr_word_store (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .rsp_corrected(rsp_corrected),
    .inj_en(inj_en), .inj_copy(inj_copy), .inj_addr(inj_addr), .inj_mask(inj_mask)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  // Issue one request; returns data, flag and latency (cycles after acceptance).
  task automatic do_req(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    got_lat = 1;
    while (!rsp_valid) begin
      @(negedge clk);
      got_lat++;
    end
    got_data = rsp_rdata;
    got_corr = rsp_corrected;
  endtask

  task automatic inject(input logic [1:0] c, input logic [AW-1:0] a, input logic [DW-1:0] m);
    @(negedge clk);
    inj_en = 1'b1; inj_copy = c; inj_addr = a; inj_mask = m;
    @(negedge clk);
    inj_en = 1'b0;
  endtask

  task automatic expect_rsp(input string tag, input logic [DW-1:0] d, input bit corr, input int lat);
    check(got_data == d, {tag, " data"}, got_data, d);
    check(got_corr == corr, {tag, " corrected"}, got_corr, corr);
    check(got_lat == lat, {tag, " latency"}, got_lat, lat);
  endtask

  task automatic t_reset();
    check(req_ready == 1'b1, "R1 req_ready", req_ready, 1);
    check(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
    do_req(1'b0, 4'd5, '0);
    expect_rsp("R1 read", 8'h00, 1'b0, 1);
  endtask

  task automatic t_write_read();
    do_req(1'b1, 4'd2, 8'hA3);
    expect_rsp("R2 write", 8'hA3, 1'b0, 1);
    do_req(1'b0, 4'd2, '0);
    expect_rsp("R3 read", 8'hA3, 1'b0, 1);
  endtask

  task automatic t_single_fault();
    for (int c = 0; c < 3; c++) begin
      do_req(1'b1, 4'd7, 8'h5A);
      inject(2'(c), 4'd7, 8'h81);
      do_req(1'b0, 4'd7, '0);
      expect_rsp("R4 R5 R6 single", 8'h5A, 1'b1, 2);
      do_req(1'b0, 4'd7, '0);
      expect_rsp("R6 after scrub", 8'h5A, 1'b0, 1);
    end
  endtask

  task automatic t_spread_fault();
    do_req(1'b1, 4'd9, 8'h0F);
    inject(2'd0, 4'd9, 8'h01);
    inject(2'd1, 4'd9, 8'h02);
    inject(2'd2, 4'd9, 8'h04);
    do_req(1'b0, 4'd9, '0);
    expect_rsp("R4 spread", 8'h0F, 1'b1, 2);
  endtask

  task automatic t_double_fault();
    do_req(1'b1, 4'd3, 8'h3C);
    inject(2'd0, 4'd3, 8'h10);
    inject(2'd1, 4'd3, 8'h10);
    do_req(1'b0, 4'd3, '0);
    expect_rsp("R4 R5 double", 8'h2C, 1'b1, 2);
    do_req(1'b0, 4'd3, '0);
    expect_rsp("R6 double rewritten", 8'h2C, 1'b0, 1);
  endtask

  task automatic t_inject_select();
    do_req(1'b1, 4'd4, 8'h66);
    inject(2'd3, 4'd4, 8'hFF);
    do_req(1'b0, 4'd4, '0);
    expect_rsp("R9 copy3 none", 8'h66, 1'b0, 1);
    do_req(1'b1, 4'd10, 8'h11);
    inject(2'd1, 4'd11, 8'hFF);
    do_req(1'b0, 4'd10, '0);
    expect_rsp("R9 other addr", 8'h11, 1'b0, 1);
  endtask

  task automatic t_scrub_stall();
    do_req(1'b1, 4'd6, 8'hC3);
    inject(2'd2, 4'd6, 8'h08);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 4'd6;
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R7 ready in scrub", req_ready, 0);
    check(rsp_valid == 1'b0, "R6 no rsp in scrub", rsp_valid, 0);
    @(negedge clk);
    check(rsp_valid && rsp_corrected && rsp_rdata == 8'hC3, "R6 scrub rsp", rsp_rdata, 8'hC3);
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 4'd2;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_wdata = 8'h00;
    check(rsp_valid == 1'b1, "R8 rsp present", rsp_valid, 1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(rsp_valid && rsp_rdata == 8'hA3 && !rsp_corrected, "R8 hold", rsp_rdata, 8'hA3);
      check(req_ready == 1'b0, "R7 ready while stalled", req_ready, 0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid && rsp_rdata == 8'h00, "R7 R2 write after release", rsp_rdata, 8'h00);
  endtask

  task automatic t_collide();
    // Write and injection on the same edge, same word.
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 4'd12; req_wdata = 8'h95;
    inj_en = 1'b1; inj_copy = 2'd1; inj_addr = 4'd12; inj_mask = 8'h40;
    @(negedge clk);
    req_valid = 1'b0; inj_en = 1'b0;
    do_req(1'b0, 4'd12, '0);
    expect_rsp("R10 write+inject", 8'h95, 1'b1, 2);
    do_req(1'b0, 4'd12, '0);
    expect_rsp("R10 clean after", 8'h95, 1'b0, 1);
    // Read and injection on the same edge.
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 4'd12;
    inj_en = 1'b1; inj_copy = 2'd0; inj_addr = 4'd12; inj_mask = 8'h02;
    @(negedge clk);
    req_valid = 1'b0; inj_en = 1'b0;
    check(rsp_valid && rsp_rdata == 8'h95 && !rsp_corrected, "R10 read+inject pre-fault", rsp_rdata, 8'h95);
    do_req(1'b0, 4'd12, '0);
    expect_rsp("R10 fault seen next", 8'h95, 1'b1, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_read();
    t_single_fault();
    t_spread_fault();
    t_double_fault();
    t_inject_select();
    t_scrub_stall();
    t_backpressure();
    t_collide();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule